// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one machine cycle at a time on an 8-bit processor bus where the low address byte and the data share the same pins. A requester presents a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then steps through clock-wide T-states. In the first state it puts out the address with an address-latch strobe. It then asserts the matching active-low strobe, stretches the cycle by whole clocks while the target holds the ready line low, and gives back the read byte with a one-cycle done pulse.

Each cycle kind has a fixed three-bit status code on the io/mem, s1 and s0 outputs. I/O cycles carry only an 8-bit port number, and the block presents it on both the high address byte and the shared bus. Opcode fetches take one extra T-state after the strobe ends. Instruction sequencing, bus hold and halt are handled elsewhere.

Top module: `mux_bus_seq`

## Requirements
- R1: After a synchronous active-low reset, rd_n, wr_n and inta_n are high, and ale, ad_oe, busy and done are low.
- R2: The status bits {io_m,s1,s0} use these codes: req_kind 0 (opcode fetch) is 011, 1 (memory read) is 010, 2 (memory write) is 001, 3 (I/O read) is 110, 4 (I/O write) is 101 and 5 (interrupt acknowledge) is 111. The code is held from T1 through the last T-state of the cycle. It is 000 while idle.
- R3: A request accepted at a clock edge starts T1 in the next cycle. In T1, ale is high for exactly that one cycle, ad_oe is high and ad_out carries address bits 7:0. a_hi carries address bits 15:8 for memory and acknowledge cycles, and the port byte (address bits 7:0) for I/O cycles, for the whole cycle.
- R4: Memory, I/O and acknowledge cycles take T1, T2 and T3. An opcode fetch adds T4. done is high for exactly one cycle, the first cycle after the last T-state, and busy is low in that cycle.
- R5: Kinds 0, 1 and 3 drive rd_n low, kinds 2 and 4 drive wr_n low, and kind 5 drives inta_n low instead of rd_n. The strobe is low in T2, in every wait state and in T3, and high in T1 and T4.
- R6: ready is sampled at the end of T2 and at the end of each wait state. Each low sample inserts one more wait state before T3, and the strobe stays low during the wait state.
- R7: For kinds 0, 1, 3 and 5, ad_in is captured at the clock edge that ends T3, where the strobe rises. rd_data shows the captured byte from the done cycle until the next such capture, so write cycles leave it unchanged.
- R8: In write cycles, ad_oe is high and ad_out carries the write byte from T2 until wr_n goes high. In read and acknowledge cycles, ad_oe is low after T1.
- R9: req_valid is ignored while busy is high. Requests with req_kind 6 or 7 are ignored and the block stays idle.
- R10: Between cycles, ad_oe is low and rd_n, wr_n and inta_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_kind | input | 3 | Cycle kind code (see R2) |
| req_addr | input | 16 | Cycle address; bits 7:0 are the port for I/O |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| a_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared bus, driven value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, sampled value |
| ale | output | 1 | Address latch enable |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| inta_n | output | 1 | Active-low interrupt acknowledge |
| ready | input | 1 | Target ready; low inserts wait states |

## Verification
A request that is presented in one cycle and taken at the next edge shows T1 in the first cycle after acceptance and T2 in the second. It then shows one wait state per low ready sample, T3, T4 for fetches, and finally done together with the new rd_data. A cycle with w wait states therefore completes 4+w cycles after acceptance, or 5+w for fetches. The bench drives each request on a falling edge and samples every T-state on the next falling edge, in the middle of the state. It sets ready during T2 and during each wait state, ahead of the edge that samples it. One extra idle cycle after done confirms that a stray request sent mid-cycle did not start anything.

// File: rtl/mbs_pkg.sv
// Shared types for the multiplexed bus cycle sequencer.
// Assumes: kind codes 0..5 are legal, 6 and 7 are not.
package mbs_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4,
        CYC_IACK  = 3'd5
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_T4
    } tstate_e;

    function automatic logic kind_legal(input logic [KIND_W-1:0] k);
        return k <= 3'd5;
    endfunction
endpackage

// File: rtl/mbs_status_enc.sv
// Decodes a cycle kind into the bus status code and strobe class.
// Assumes: the kind is legal; unknown codes decode to a quiet memory read.
module mbs_status_enc
    import mbs_pkg::*;
(
    input  cyc_kind_e kind,
    output logic      io_m,
    output logic      s1,
    output logic      s0,
    output logic      rd_kind,
    output logic      wr_kind,
    output logic      ack_kind,
    output logic      fetch_kind
);
    // Status code and strobe class per kind.
    always_comb begin
        {io_m, s1, s0} = 3'b010;
        rd_kind = 1'b0;
        wr_kind = 1'b0;
        ack_kind = 1'b0;
        fetch_kind = 1'b0;
        case (kind)
            CYC_FETCH: begin {io_m, s1, s0} = 3'b011; rd_kind = 1'b1; fetch_kind = 1'b1; end
            CYC_MRD:   begin {io_m, s1, s0} = 3'b010; rd_kind = 1'b1; end
            CYC_MWR:   begin {io_m, s1, s0} = 3'b001; wr_kind = 1'b1; end
            CYC_IORD:  begin {io_m, s1, s0} = 3'b110; rd_kind = 1'b1; end
            CYC_IOWR:  begin {io_m, s1, s0} = 3'b101; wr_kind = 1'b1; end
            CYC_IACK:  begin {io_m, s1, s0} = 3'b111; ack_kind = 1'b1; end
            default:   begin {io_m, s1, s0} = 3'b010; end
        endcase
    end
endmodule

// File: rtl/mbs_tstate_ctl.sv
// T-state controller: steps T1, T2, waits, T3 and an optional T4.
// Assumes: start is only raised while idle; ready is valid at every edge.
module mbs_tstate_ctl
    import mbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    fetch_kind,
    input  logic    ready,
    output tstate_e state,
    output logic    done
);
    tstate_e nxt;

    // Next T-state; ready is consulted only when leaving T2 or a wait state.
    always_comb begin
        nxt = state;
        case (state)
            TS_IDLE: if (start) nxt = TS_T1;
            TS_T1:   nxt = TS_T2;
            TS_T2:   nxt = ready ? TS_T3 : TS_TW;
            TS_TW:   nxt = ready ? TS_T3 : TS_TW;
            TS_T3:   nxt = fetch_kind ? TS_T4 : TS_IDLE;
            TS_T4:   nxt = TS_IDLE;
            default: nxt = TS_IDLE;
        endcase
    end

    // State register and one-cycle done pulse after the final T-state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TS_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == TS_T3 && !fetch_kind) || state == TS_T4;
        end
    end
endmodule

// File: rtl/mux_bus_seq.sv
// Top of the multiplexed bus cycle sequencer. Latches a request while idle,
// then drives address, status, strobes and the shared bus per T-state.
// Assumes: ADDR_W > DATA_W; the I/O port is the low DATA_W address bits.
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [KIND_W-1:0]    req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    input  logic [DATA_W-1:0]    ad_in,
    output logic                 ale,
    output logic                 io_m,
    output logic                 s1,
    output logic                 s0,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 inta_n,
    input  logic                 ready
);
    localparam int HI_W = ADDR_W - DATA_W;

    cyc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_q;
    tstate_e           state;
    logic              start, strobe_ph;
    logic              st_io, st_s1, st_s0;
    logic              rd_kind, wr_kind, ack_kind, fetch_kind;

    assign start = req_valid && state == TS_IDLE && kind_legal(req_kind);

    mbs_status_enc u_enc (
        .kind(kind_q), .io_m(st_io), .s1(st_s1), .s0(st_s0),
        .rd_kind(rd_kind), .wr_kind(wr_kind), .ack_kind(ack_kind),
        .fetch_kind(fetch_kind)
    );

    mbs_tstate_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .start(start), .fetch_kind(fetch_kind),
        .ready(ready), .state(state), .done(done)
    );

    // Capture the request fields when a cycle is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CYC_MRD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            kind_q  <= cyc_kind_e'(req_kind);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the read byte at the edge that ends T3 (strobe rising).
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (state == TS_T3 && (rd_kind || ack_kind))
            rd_q <= ad_in;
    end

    // Bus outputs decoded from the current T-state and latched request.
    always_comb begin
        busy      = state != TS_IDLE;
        ale       = state == TS_T1;
        strobe_ph = state == TS_T2 || state == TS_TW || state == TS_T3;
        rd_n      = !(strobe_ph && rd_kind);
        wr_n      = !(strobe_ph && wr_kind);
        inta_n    = !(strobe_ph && ack_kind);
        ad_oe     = ale || (strobe_ph && wr_kind);
        if (ale)
            ad_out = addr_q[DATA_W-1:0];
        else if (strobe_ph && wr_kind)
            ad_out = wdata_q;
        else
            ad_out = '0;
        if (!busy)
            a_hi = '0;
        else if (kind_q == CYC_IORD || kind_q == CYC_IOWR)
            a_hi = HI_W'(addr_q[DATA_W-1:0]);
        else
            a_hi = addr_q[ADDR_W-1:DATA_W];
        {io_m, s1, s0} = busy ? {st_io, st_s1, st_s0} : 3'b000;
        rd_data = rd_q;
    end
endmodule

// File: rtl/mbs_checker.sv
// Port-level properties of the bus sequencer, bound to the top module.
module mbs_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ale,
    input logic ad_oe,
    input logic io_m,
    input logic s1,
    input logic s0,
    input logic rd_n,
    input logic wr_n,
    input logic inta_n
);
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R3
    AST_START_ALE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ale); // R3
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $countones({!rd_n, !wr_n, !inta_n}) <= 1); // R5
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (rd_n && wr_n && inta_n && !ad_oe)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy ##1 !done); // R4
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && !ale) |-> $stable({io_m, s1, s0})); // R2
endmodule

bind mux_bus_seq mbs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale),
    .ad_oe(ad_oe), .io_m(io_m), .s1(s1), .s0(s0),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n)
);

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] req_wdata = 8'h0;
    logic busy, done, ad_oe, ale, io_m, s1, s0, rd_n, wr_n, inta_n;
    logic [7:0] rd_data, a_hi, ad_out, ad_in, lat_lo, lat_hi;
    logic ready = 1'b1;
    int errors = 0;
    int checks = 0;
    logic [7:0] last_rd = 8'h00;

    always #2.5 clk = ~clk;

    mux_bus_seq u_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .ready(ready)
    );

    function automatic logic [7:0] mem_fn(input logic [7:0] hi, input logic [7:0] lo);
        return lo ^ {hi[3:0], hi[7:4]} ^ 8'h3C;
    endfunction

    function automatic logic [2:0] stat_fn(input logic [2:0] k);
        case (k)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

    // Target model: latch the address on ALE, return a byte while strobed.
    always @(negedge clk) if (ale) begin lat_lo <= ad_out; lat_hi <= a_hi; end
    always_comb ad_in = (!rd_n || !inta_n) ? mem_fn(lat_hi, lat_lo) : 8'h00;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] bus_vec();
        return {ale, ad_oe, rd_n, wr_n, inta_n, io_m, s1, s0, busy, done};
    endfunction

    task automatic run_cyc(input logic [2:0] k, input logic [15:0] addr,
                           input logic [7:0] wd, input int waits, input bit stray);
        logic io, rk, wk, ik;
        logic [7:0] ehi, ed;
        logic [2:0] st;
        logic [9:0] e;
        io = (k == 3'd3 || k == 3'd4);
        rk = (k == 3'd0 || k == 3'd1 || k == 3'd3);
        wk = (k == 3'd2 || k == 3'd4);
        ik = (k == 3'd5);
        ehi = io ? addr[7:0] : addr[15:8];
        st = stat_fn(k);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = addr; req_wdata = wd; ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        e = {1'b1, 1'b1, 3'b111, st, 1'b1, 1'b0};
        check(bus_vec() == e, "R2/R3 T1 bus", {22'd0, bus_vec()}, {22'd0, e});
        check({a_hi, ad_out} == {ehi, addr[7:0]}, "R3 address", {16'd0, a_hi, ad_out}, {16'd0, ehi, addr[7:0]});
        if (stray) begin req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h1234; end
        @(negedge clk);
        e = {1'b0, wk, !rk, !wk, !ik, st, 1'b1, 1'b0};
        check(bus_vec() == e, "R5/R8 T2 bus", {22'd0, bus_vec()}, {22'd0, e});
        if (wk) check(ad_out == wd, "R8 write data", {24'd0, ad_out}, {24'd0, wd});
        ready = (waits == 0);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            check(bus_vec() == e, "R6 wait state", {22'd0, bus_vec()}, {22'd0, e});
            if (wk) check(ad_out == wd, "R8 data held in wait", {24'd0, ad_out}, {24'd0, wd});
            ready = (w == waits - 1);
        end
        @(negedge clk);
        check(bus_vec() == e, "R5 T3 bus", {22'd0, bus_vec()}, {22'd0, e});
        ready = 1'b1; req_valid = 1'b0;
        if (k == 3'd0) begin
            @(negedge clk);
            e = {1'b0, 1'b0, 3'b111, st, 1'b1, 1'b0};
            check(bus_vec() == e, "R4 T4 of fetch", {22'd0, bus_vec()}, {22'd0, e});
        end
        @(negedge clk);
        e = {1'b0, 1'b0, 3'b111, 3'b000, 1'b0, 1'b1};
        check(bus_vec() == e, "R4/R10 done cycle", {22'd0, bus_vec()}, {22'd0, e});
        if (rk || ik) last_rd = mem_fn(ehi, addr[7:0]);
        ed = last_rd;
        check(rd_data == ed, "R7 read data", {24'd0, rd_data}, {24'd0, ed});
        @(negedge clk);
        e = {1'b0, 1'b0, 3'b111, 3'b000, 1'b0, 1'b0};
        check(bus_vec() == e, "R9/R10 idle after done", {22'd0, bus_vec()}, {22'd0, e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bus_vec() == 10'b0011100000, "R1 reset state", {22'd0, bus_vec()}, 32'h0E0);
        rst_n = 1'b1;
        // Directed: each kind, no waits.
        for (int k = 0; k < 6; k++) run_cyc(3'(k), 16'hA55A + 16'(k * 257), 8'hC3 ^ 8'(k), 0, 1'b0);
        // Directed corners: long waits, stray request mid-cycle.
        run_cyc(3'd0, 16'hFFF0, 8'h00, 5, 1'b0);
        run_cyc(3'd4, 16'h00FF, 8'h81, 3, 1'b1);
        run_cyc(3'd5, 16'h8800, 8'h00, 1, 1'b1);
        // Illegal kinds are dropped.
        for (int k = 6; k < 8; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_kind = 3'(k);
            @(negedge clk);
            req_valid = 1'b0;
            check(!busy && !ale, "R9 illegal kind ignored", {30'd0, busy, ale}, 32'd0);
        end
        // Random mix with a fixed seed.
        void'($urandom(32'd4242));
        for (int i = 0; i < 60; i++)
            run_cyc(3'($urandom % 6), 16'($urandom), 8'($urandom), int'($urandom % 4), 1'($urandom));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule